// File: doc/BRIEF.md
# Audio Sample Format Converter

This block sits on the path between an audio device and a routing fabric. It takes a stream of audio samples in one format and hands out the same audio in another format. A format is a sample width and a channel count. Samples are signed and left-justified in a 32-bit container. The width of each sample can be reduced, by rounding or by chopping, or widened, with the new low bits filled by zeros, by ones or by pseudo-random bits. The channel count can go from stereo to mono, taking one channel or the average of the two. It can also go from mono to stereo, with the second channel either zero or a copy of the first.

A single control word carries both formats, the conversion modes and a direction bit. The direction bit decides which format is the source and which is the destination. Input and output are valid/ready streams with one sample per beat. A frame is the group of source samples that belongs to one sampling instant. The control word is taken only when the first sample of a frame is accepted, so a frame is never converted under two configurations.

Top module: `audio_fmt_conv`

## Requirements
- R1: Control word layout: client width code [2:0], hub width code [5:3], client channels-1 [8:6], hub channels-1 [11:9], narrow mode [12], fill mode [14:13], stereo-to-mono mode [16:15], mono-to-stereo mode [17], direction [18]. A width code n means 4*(n+1) bits at the top of the 32-bit container. Input bits below the source width are ignored. Output bits below the destination width are always zero.
- R2: With direction 0, the client fields give the source format and the hub fields give the destination format. With direction 1, these roles are swapped.
- R3: When the destination is narrower and narrow mode is 1 (chop), the output is the top destination-width bits of the source sample.
- R4: When the destination is narrower and narrow mode is 0 (round), half of a destination LSB is added before truncation. A positive sample that would wrap saturates to the most positive destination value.
- R5: When the destination is wider, fill mode 0 puts zeros in the new low bits and fill mode 1 puts ones there. Mode 3 acts as mode 0.
- R6: Fill mode 2 puts pseudo-random bits in the new low bits. Container bit i takes bit (i mod 16) of a 16-bit LFSR. The LFSR starts at 0xACE1 after reset and shifts left. Its new bit 0 is the XOR of bits 15, 13, 12 and 10. The output uses the state that is current before the advance. The LFSR advances once for every output beat and is never zero.
- R7: When the source has 2 channels and the destination has 1, stereo-to-mono mode 0 outputs the first sample and mode 1 outputs the second. Mode 3 acts as mode 0. Each pair of inputs gives one output.
- R8: Stereo-to-mono mode 2 outputs the floor of the sum of the two source-width samples, shifted right by one. Width conversion is then applied to the result.
- R9: When the source has 1 channel and the destination has 2, each input gives two outputs. The first is the converted sample. The second is zero in mono-to-stereo mode 0. In mode 1 it is a second conversion of the same sample, which takes its own LFSR state. No input is accepted while the second output is pending.
- R10: For any other pair of channel counts, a frame is as long as the source channel count, and each sample is converted on its own.
- R11: The control word is latched when the first sample of a frame is accepted. Changes made during the rest of the frame have no effect on that frame.
- R12: After reset, out_valid is 0 and in_ready is 1. An output that is not taken stays valid and unchanged. Outputs appear in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg | input | 19 | Control word (layout in R1) |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | 32 | Input sample, left-justified signed |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream takes the output sample |
| out_data | output | 32 | Output sample, left-justified signed |

## Verification
The bench builds the converter with its default parameters: a 32-bit container, which gives eight width steps of 4 bits each, and a 16-bit LFSR with taps 0xB400 and seed 0xACE1. With these values every pair of width codes can be reached, including the full 4-to-32 widening and the 32-to-4 rounding, where saturation and the pseudo-random fill show up in most bits. Frames of up to eight channels exercise the frame counter at its wrap. Downstream back-pressure is random, so the pending second output of mono-to-stereo and the latching of the control word are tested under stalls.

// File: rtl/afc_pkg.sv
package afc_pkg;

    localparam int AFC_CODE_W = 3;
    localparam int AFC_CFG_W  = 19;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_ONE  = 2'd1,
        FILL_RAND = 2'd2,
        FILL_RSVD = 2'd3
    } afc_fill_e;

    typedef enum logic [1:0] {
        DN_FIRST  = 2'd0,
        DN_SECOND = 2'd1,
        DN_AVG    = 2'd2,
        DN_RSVD   = 2'd3
    } afc_down_e;

    typedef enum logic [1:0] {
        K_PASS = 2'd0,
        K_DOWN = 2'd1,
        K_UP   = 2'd2
    } afc_kind_e;

    // field order fixes the bit positions listed in the brief
    typedef struct packed {
        logic                  dir;
        logic                  up_copy;
        afc_down_e             down_sel;
        afc_fill_e             fill;
        logic                  narrow_chop;
        logic [AFC_CODE_W-1:0] hub_ch;
        logic [AFC_CODE_W-1:0] cli_ch;
        logic [AFC_CODE_W-1:0] hub_w;
        logic [AFC_CODE_W-1:0] cli_w;
    } afc_cfg_t;

    function automatic logic [AFC_CODE_W-1:0] src_w_of(afc_cfg_t c);
        return c.dir ? c.hub_w : c.cli_w;
    endfunction

    function automatic logic [AFC_CODE_W-1:0] dst_w_of(afc_cfg_t c);
        return c.dir ? c.cli_w : c.hub_w;
    endfunction

    function automatic logic [AFC_CODE_W-1:0] src_ch_of(afc_cfg_t c);
        return c.dir ? c.hub_ch : c.cli_ch;
    endfunction

    function automatic afc_kind_e kind_of(afc_cfg_t c);
        logic [AFC_CODE_W-1:0] s;
        logic [AFC_CODE_W-1:0] d;
        s = c.dir ? c.hub_ch : c.cli_ch;
        d = c.dir ? c.cli_ch : c.hub_ch;
        if (s == AFC_CODE_W'(1) && d == AFC_CODE_W'(0))
            return K_DOWN;
        else if (s == AFC_CODE_W'(0) && d == AFC_CODE_W'(1))
            return K_UP;
        else
            return K_PASS;
    endfunction

endpackage

// File: rtl/afc_lfsr.sv
module afc_lfsr #(
    parameter int               W    = 16,
    parameter logic [W-1:0]     TAPS = 16'hB400,
    parameter logic [W-1:0]     SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] state
);

    always_ff @(posedge clk) begin
        if (rst)
            state <= SEED;
        else if (step)
            state <= {state[W-2:0], ^(state & TAPS)};
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state != '0); // R6

endmodule

// File: rtl/afc_width_conv.sv
module afc_width_conv
    import afc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LFSR_W = 16
) (
    input  logic [DATA_W-1:0]     sample,
    input  logic [AFC_CODE_W-1:0] src_w,
    input  logic [AFC_CODE_W-1:0] dst_w,
    input  logic                  chop,
    input  afc_fill_e             fill,
    input  logic [LFSR_W-1:0]     lfsr,
    output logic [DATA_W-1:0]     result
);

    localparam int STEP = DATA_W / (2 ** AFC_CODE_W);

    logic [DATA_W-1:0] pat;
    logic [DATA_W-1:0] keep_s;
    logic [DATA_W-1:0] keep_d;
    logic [DATA_W-1:0] xm;
    logic [DATA_W-1:0] new_bits;
    logic [DATA_W:0]   half;
    logic [DATA_W:0]   rsum;
    int                ws;
    int                wd;

    for (genvar i = 0; i < DATA_W; i++) begin : g_pat
        assign pat[i] = lfsr[i % LFSR_W];
    end

    always_comb begin
        ws       = STEP * (int'(src_w) + 1);
        wd       = STEP * (int'(dst_w) + 1);
        keep_s   = {DATA_W{1'b1}} << (DATA_W - ws);
        keep_d   = {DATA_W{1'b1}} << (DATA_W - wd);
        xm       = sample & keep_s;
        new_bits = keep_d & ~keep_s;
        half     = '0;
        rsum     = '0;
        result   = xm;
        if (dst_w < src_w) begin
            if (chop) begin
                result = xm & keep_d;
            end else begin
                half = {{DATA_W{1'b0}}, 1'b1} << (DATA_W - 1 - wd);
                rsum = {xm[DATA_W-1], xm} + half;
                if (rsum[DATA_W] != rsum[DATA_W-1])
                    result = {1'b0, {(DATA_W-1){1'b1}}} & keep_d;
                else
                    result = rsum[DATA_W-1:0] & keep_d;
            end
        end else if (dst_w > src_w) begin
            case (fill)
                FILL_ONE:  result = xm | new_bits;
                FILL_RAND: result = xm | (pat & new_bits);
                default:   result = xm;
            endcase
        end
    end

endmodule

// File: rtl/afc_frame_seq.sv
module afc_frame_seq
    import afc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  afc_cfg_t          cfg_in,
    input  logic              acc,
    input  logic              pend_take,
    input  logic [DATA_W-1:0] in_data,
    output afc_cfg_t          eff_cfg,
    output afc_cfg_t          cfg_q,
    output afc_kind_e         kind,
    output logic              first,
    output logic [DATA_W-1:0] hold_q,
    output logic              pend_q,
    output logic [DATA_W-1:0] pend_x_q
);

    logic [AFC_CODE_W-1:0] pos_q;

    assign first   = (pos_q == '0);
    assign eff_cfg = first ? cfg_in : cfg_q;
    assign kind    = kind_of(eff_cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= '0;
            cfg_q    <= '0;
            hold_q   <= '0;
            pend_q   <= 1'b0;
            pend_x_q <= '0;
        end else begin
            if (acc) begin
                pos_q <= (pos_q == src_ch_of(eff_cfg)) ? '0 : pos_q + 1'b1;
                if (first)
                    cfg_q <= cfg_in;
                if (kind == K_DOWN && first)
                    hold_q <= in_data;
            end
            if (acc && kind == K_UP) begin
                pend_q   <= 1'b1;
                pend_x_q <= in_data;
            end else if (pend_take) begin
                pend_q <= 1'b0;
            end
        end
    end

    AST_FRAME_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        !first |=> $stable(cfg_q)); // R11

    AST_PEND_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> !acc); // R9

endmodule

// File: rtl/audio_fmt_conv.sv
module audio_fmt_conv
    import afc_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AFC_CFG_W-1:0] cfg,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [DATA_W-1:0]    in_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [DATA_W-1:0]    out_data
);

    localparam int STEP = DATA_W / (2 ** AFC_CODE_W);

    afc_cfg_t              cfg_in;
    afc_cfg_t              eff_cfg;
    afc_cfg_t              cfg_q;
    afc_cfg_t              conv_cfg;
    afc_kind_e             kind;
    logic                  first;
    logic [DATA_W-1:0]     hold_q;
    logic                  pend_q;
    logic [DATA_W-1:0]     pend_x_q;
    logic                  load_ok;
    logic                  acc;
    logic                  load;
    logic [LFSR_W-1:0]     lfsr_q;
    logic [DATA_W-1:0]     mix_keep;
    logic [DATA_W-1:0]     mix_a;
    logic [DATA_W-1:0]     mix_b;
    logic [DATA_W:0]       mix_sum;
    logic [DATA_W-1:0]     mix_out;
    logic [DATA_W-1:0]     conv_in;
    logic [DATA_W-1:0]     conv_out;
    logic [DATA_W-1:0]     next_data;
    logic [AFC_CODE_W-1:0] out_dw_q;
    logic [DATA_W-1:0]     out_keep;

    assign cfg_in   = afc_cfg_t'(cfg);
    assign load_ok  = !out_valid || out_ready;
    assign in_ready = load_ok && !pend_q;
    assign acc      = in_valid && in_ready;
    assign load     = pend_q ? load_ok : (acc && !(kind == K_DOWN && first));
    assign conv_cfg = pend_q ? cfg_q : eff_cfg;

    afc_frame_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cfg_in    (cfg_in),
        .acc       (acc),
        .pend_take (pend_q && load_ok),
        .in_data   (in_data),
        .eff_cfg   (eff_cfg),
        .cfg_q     (cfg_q),
        .kind      (kind),
        .first     (first),
        .hold_q    (hold_q),
        .pend_q    (pend_q),
        .pend_x_q  (pend_x_q)
    );

    afc_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .step  (load),
        .state (lfsr_q)
    );

    // two-channel reduction on source-width samples
    always_comb begin
        mix_keep = {DATA_W{1'b1}} << (DATA_W - STEP * (int'(src_w_of(eff_cfg)) + 1));
        mix_a    = hold_q & mix_keep;
        mix_b    = in_data & mix_keep;
        mix_sum  = {mix_a[DATA_W-1], mix_a} + {mix_b[DATA_W-1], mix_b};
        case (eff_cfg.down_sel)
            DN_SECOND: mix_out = in_data;
            DN_AVG:    mix_out = mix_sum[DATA_W:1];
            default:   mix_out = hold_q;
        endcase
    end

    assign conv_in = pend_q ? pend_x_q : ((kind == K_DOWN) ? mix_out : in_data);

    afc_width_conv #(.DATA_W(DATA_W), .LFSR_W(LFSR_W)) u_wconv (
        .sample (conv_in),
        .src_w  (src_w_of(conv_cfg)),
        .dst_w  (dst_w_of(conv_cfg)),
        .chop   (conv_cfg.narrow_chop),
        .fill   (conv_cfg.fill),
        .lfsr   (lfsr_q),
        .result (conv_out)
    );

    assign next_data = (pend_q && !cfg_q.up_copy) ? '0 : conv_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_dw_q  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= next_data;
            out_dw_q  <= dst_w_of(conv_cfg);
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign out_keep = {DATA_W{1'b1}} << (DATA_W - STEP * (int'(out_dw_q) + 1));

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R12

    AST_PEND_STALL: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> !in_ready); // R9

    AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data & ~out_keep) == '0); // R1

endmodule

// File: tb/sim_audio_fmt_conv.sv
`timescale 1ns/1ps
module sim_audio_fmt_conv;

    localparam int LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [18:0] cfg_r = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;

    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [15:0] lfsr_m = 16'hACE1;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] fr[8];

    always #2 clk = ~clk;

    audio_fmt_conv u0 (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg_r),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    function automatic logic [15:0] lf_next(logic [15:0] l);
        return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
    endfunction

    function automatic logic [18:0] mk(int cw, int hw, int cch, int hch, bit chop,
                                       int fill, int dsel, bit cp, bit dir);
        return {dir, cp, 2'(dsel), 2'(fill), chop, 3'(hch), 3'(cch), 3'(hw), 3'(cw)};
    endfunction

    function automatic logic [31:0] kmask(int code);
        return 32'hFFFF_FFFF << (32 - 4 * (code + 1));
    endfunction

    // expected width conversion (R3 R4 R5 R6)
    function automatic logic [31:0] mconv(logic [31:0] x, int sw, int dw, bit chop,
                                          int fill, logic [15:0] lf);
        logic [31:0] ks = kmask(sw);
        logic [31:0] kd = kmask(dw);
        logic [31:0] xm = x & ks;
        longint      s;
        if (dw < sw) begin
            if (chop) return xm & kd;
            s = longint'($signed(xm)) + (longint'(1) << (31 - 4 * (dw + 1)));
            if (s > 64'sh7FFF_FFFF) return 32'h7FFF_FFFF & kd;
            return s[31:0] & kd;
        end else if (dw > sw) begin
            if (fill == 1) return xm | (kd & ~ks);
            if (fill == 2) return xm | ({lf, lf} & kd & ~ks);
            return xm;
        end
        return xm;
    endfunction

    task automatic push(logic [31:0] v, string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
        lfsr_m = lf_next(lfsr_m);
    endtask

    task automatic check(bit ok, string t, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", t, got, exp);
        end
    endtask

    // starts and ends at posedge + 1
    task automatic drive(logic [31:0] x);
        bit ok;
        in_valid = 1'b1;
        in_data  = x;
        do begin
            @(negedge clk);
            ok = in_ready;
            @(posedge clk);
            #1;
        end while (!ok);
        in_valid = 1'b0;
    endtask

    // model-driven frame; scramble changes cfg after the first sample (R11)
    task automatic do_frame(logic [18:0] c, bit scramble, string t);
        bit          dir  = c[18];
        int          sw   = dir ? int'(c[5:3])  : int'(c[2:0]);
        int          dw   = dir ? int'(c[2:0])  : int'(c[5:3]);
        int          sch  = dir ? int'(c[11:9]) : int'(c[8:6]);
        int          dch  = dir ? int'(c[8:6])  : int'(c[11:9]);
        bit          chop = c[12];
        int          fill = int'(c[14:13]);
        int          dsel = int'(c[16:15]);
        bit          cp   = c[17];
        logic [31:0] m;
        longint      s;
        if (sch == 1 && dch == 0) begin
            s = longint'($signed(fr[0] & kmask(sw))) + longint'($signed(fr[1] & kmask(sw)));
            s = s >>> 1;
            m = (dsel == 1) ? fr[1] : (dsel == 2) ? s[31:0] : fr[0];
            push(mconv(m, sw, dw, chop, fill, lfsr_m), t);
        end else if (sch == 0 && dch == 1) begin
            push(mconv(fr[0], sw, dw, chop, fill, lfsr_m), t);
            push(cp ? mconv(fr[0], sw, dw, chop, fill, lfsr_m) : 32'h0, t);
        end else begin
            for (int i = 0; i <= sch; i++)
                push(mconv(fr[i], sw, dw, chop, fill, lfsr_m), t);
        end
        cfg_r = c;
        for (int i = 0; i <= sch; i++) begin
            drive(fr[i]);
            if (scramble) cfg_r = 19'($urandom);
        end
    endtask

    // hand-computed frame
    task automatic lit(logic [18:0] c, int nin, int nout, logic [31:0] e0,
                       logic [31:0] e1, string t);
        push(e0, t);
        if (nout == 2) push(e1, t);
        cfg_r = c;
        for (int i = 0; i < nin; i++) drive(fr[i]);
    endtask

    // output consumer: order, values and stall behaviour (R12)
    initial begin
        bit          stalled = 1'b0;
        logic [31:0] held = '0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (stalled)
                    check(out_valid && out_data == held, "R12 hold", out_data, held);
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R12 extra output", out_data, 32'h0);
                    end else begin
                        check(out_data == exp_q[0], tag_q[0], out_data, exp_q[0]);
                        void'(exp_q.pop_front());
                        void'(tag_q.pop_front());
                    end
                end
                stalled = out_valid && !out_ready;
                held    = out_data;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #1;
            out_ready = (!rst) && (($urandom % 10) < 7);
        end
    end

    initial begin
        #(LIMIT * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R12 watchdog expired, pending=%0d exp=0", exp_q.size());
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R12 reset out_valid", 32'(out_valid), 32'h0);
        check(in_ready == 1'b1, "R12 reset in_ready", 32'(in_ready), 32'h1);
        @(posedge clk);
        #1;

        // R3 chop 16 -> 8, low input bits ignored (R1)
        fr[0] = 32'h1234_5678;
        lit(mk(3, 1, 0, 0, 1, 0, 0, 0, 0), 1, 1, 32'h1200_0000, 0, "R3 chop");
        // R4 round up, saturate, negative
        fr[0] = 32'h1280_0000;
        lit(mk(3, 1, 0, 0, 0, 0, 0, 0, 0), 1, 1, 32'h1300_0000, 0, "R4 round");
        fr[0] = 32'h7FF0_0000;
        lit(mk(3, 1, 0, 0, 0, 0, 0, 0, 0), 1, 1, 32'h7F00_0000, 0, "R4 saturate");
        fr[0] = 32'hFF80_0000;
        lit(mk(3, 1, 0, 0, 0, 0, 0, 0, 0), 1, 1, 32'h0000_0000, 0, "R4 negative");
        // R5 widen 8 -> 16 zero and ones
        fr[0] = 32'hA5FF_FFFF;
        lit(mk(1, 3, 0, 0, 0, 0, 0, 0, 0), 1, 1, 32'hA500_0000, 0, "R5 zero fill");
        lit(mk(1, 3, 0, 0, 0, 1, 0, 0, 0), 1, 1, 32'hA5FF_0000, 0, "R5 ones fill");
        // R2 direction 1: hub 8 bits is source, client 16 bits destination
        fr[0] = 32'h3C12_3456;
        lit(mk(3, 1, 0, 0, 0, 1, 0, 0, 1), 1, 1, 32'h3CFF_0000, 0, "R2 direction");
        // R7 stereo to mono pick
        fr[0] = 32'h1111_0000; fr[1] = 32'h2222_0000;
        lit(mk(3, 3, 1, 0, 0, 0, 1, 0, 0), 2, 1, 32'h2222_0000, 0, "R7 second");
        lit(mk(3, 3, 1, 0, 0, 0, 0, 0, 0), 2, 1, 32'h1111_0000, 0, "R7 first");
        // R8 average with floor
        fr[0] = 32'h0003_0000; fr[1] = 32'h0;
        lit(mk(3, 3, 1, 0, 0, 0, 2, 0, 0), 2, 1, 32'h0001_0000, 0, "R8 average");
        fr[0] = 32'hFFFF_0000; fr[1] = 32'h0;
        lit(mk(3, 3, 1, 0, 0, 0, 2, 0, 0), 2, 1, 32'hFFFF_0000, 0, "R8 floor");
        // R9 mono to stereo
        fr[0] = 32'h4321_0000;
        lit(mk(3, 3, 0, 1, 0, 0, 0, 0, 0), 1, 2, 32'h4321_0000, 32'h0, "R9 zero");
        lit(mk(3, 3, 0, 1, 0, 0, 0, 1, 0), 1, 2, 32'h4321_0000, 32'h4321_0000, "R9 copy");
        // R6 pseudo-random fill 4 -> 32, and copied beats each with own state
        fr[0] = 32'h5000_0000;
        do_frame(mk(0, 7, 0, 0, 0, 2, 0, 0, 0), 1'b0, "R6 random fill");
        do_frame(mk(0, 7, 0, 1, 0, 2, 0, 1, 0), 1'b0, "R6 R9 random copy");
        // R10 three to five channels, each converted alone
        fr[0] = 32'h8123_4567; fr[1] = 32'h7FFF_FFFF; fr[2] = 32'h0000_1000;
        do_frame(mk(5, 2, 2, 4, 0, 0, 0, 0, 0), 1'b0, "R10 passthrough");
        // R11 cfg changed mid-frame
        for (int i = 0; i < 8; i++) fr[i] = $urandom;
        do_frame(mk(7, 1, 7, 7, 0, 0, 0, 0, 0), 1'b1, "R11 latched");
        do_frame(mk(2, 6, 1, 0, 1, 1, 2, 0, 0), 1'b1, "R11 latched mix");

        // constrained random frames
        for (int n = 0; n < 300; n++) begin
            int pick = $urandom % 4;
            int sc = (pick == 0) ? 1 : (pick == 1) ? 0 : int'($urandom % 8);
            int dc = (pick == 0) ? 0 : (pick == 1) ? 1 : int'($urandom % 8);
            for (int i = 0; i < 8; i++) fr[i] = $urandom;
            if (n % 2 == 0)
                do_frame(mk($urandom % 8, $urandom % 8, sc, dc, $urandom % 2, $urandom % 4,
                            $urandom % 4, $urandom % 2, 1'b0), n % 5 == 0, "R1 R10 random tx");
            else
                do_frame(mk($urandom % 8, $urandom % 8, dc, sc, $urandom % 2, $urandom % 4,
                            $urandom % 4, $urandom % 2, 1'b1), n % 5 == 0, "R2 R11 random rx");
        end

        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule